// File: doc/BRIEF.md
# Linear DMA Copy Command Splitter

This block turns a single linear copy request into the command words that an asynchronous copy engine consumes. A request carries a 40-bit source address, a 40-bit destination address and a length in bytes. The block accepts it over a valid/ready handshake and picks the element size. Whole 32-bit words are used when both addresses and the length are multiples of four; single bytes are used in every other case. The transfer is then split into packets of at most 0xFFFFF elements, and each packet goes out as five 32-bit words over a second valid/ready handshake.

Between packets both addresses move forward by the span the previous packet covered, wrapping at 40 bits. When the last word of the last packet has been taken, `done` pulses for one cycle and a new request can be accepted. A zero-length request emits nothing and only pulses `done`.

Top module: `dma_copy_splitter`

## Requirements
- R1: Every packet header holds the copy opcode 0x3 in bits 31:28, the sub-command in bits 27:20 and the element count in bits 19:0.
- R2: When source address, destination address and byte length all have bits 1:0 equal to zero, the sub-command is 0x00 and counts are in 4-byte elements (length divided by four).
- R3: In any other case the sub-command is 0x40 and counts are in bytes.
- R4: Each packet carries at most 0xFFFFF elements. A transfer uses ceil(elements / 0xFFFFF) packets, every packet but the last carries exactly 0xFFFFF, and no packet carries zero.
- R5: A packet is five words sent in this order: header, destination address bits 31:0, source address bits 31:0, destination bits 39:32 in bits 7:0, source bits 39:32 in bits 7:0. Bits 31:8 of the last two words are zero.
- R6: After each packet both addresses increase by count x element size (4 or 1 bytes), modulo 2^40.
- R7: A zero-length request emits no word, and `done` is high in the cycle after it is accepted.
- R8: `req_ready` is low from the cycle after an acceptance until `done` is high. Requests presented in that time are ignored and leave the word stream unchanged.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and `cmd_data` hold their values into the next cycle.
- R10: `done` is high for exactly one cycle, the cycle after the handshake of the final word.
- R11: After reset `cmd_valid` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_src | input | 40 | Source byte address |
| req_dst | input | 40 | Destination byte address |
| req_len | input | SIZE_W | Copy length in bytes |
| cmd_valid | output | 1 | Command word present |
| cmd_ready | input | 1 | Consumer takes the word |
| cmd_data | output | 32 | Command word |
| done | output | 1 | One-cycle pulse when the request has been fully emitted |

## Verification
The main function is tried with all addresses and the length aligned, where only 4-byte mode may be chosen. It is also tried with an odd source, with an offset destination, and with an odd length, so that each of the three conditions is shown to force byte mode on its own. Long transfers separate the packet splitting cases: one exactly at the packet limit, one just past it in 4-byte mode, and one needing three byte-mode packets. These runs start at addresses that carry across bit 32 and across bit 40, which shows that the upper address bytes advance and wrap. Varying `cmd_ready` patterns and requests presented while busy show that words are held during back-pressure and that stray requests are ignored.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
    localparam int ADDR_W   = 40;
    localparam int WORD_W   = 32;
    localparam int HI_W     = ADDR_W - WORD_W;
    localparam int CNT_W    = 20;
    localparam int SUB_W    = 8;
    localparam int OPC_W    = WORD_W - CNT_W - SUB_W;
    localparam int WIDX_W   = 3;

    localparam logic [OPC_W-1:0] OPC_COPY  = 4'h3;
    localparam logic [SUB_W-1:0] SUB_WORDS = 8'h00;
    localparam logic [SUB_W-1:0] SUB_BYTES = 8'h40;
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

    typedef enum logic [WIDX_W-1:0] {
        W_HDR    = 3'd0,
        W_DST_LO = 3'd1,
        W_SRC_LO = 3'd2,
        W_DST_HI = 3'd3,
        W_SRC_HI = 3'd4
    } word_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } split_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } addr_pair_t;

    function automatic logic [WORD_W-1:0] build_header(
        input logic             words_mode,
        input logic [CNT_W-1:0] count
    );
        return {OPC_COPY, (words_mode ? SUB_WORDS : SUB_BYTES), count};
    endfunction

    function automatic logic [WORD_W-1:0] hi_word(input logic [ADDR_W-1:0] a);
        return {{(WORD_W-HI_W){1'b0}}, a[ADDR_W-1:WORD_W]};
    endfunction
endpackage

// File: rtl/dma_split_mode.sv
module dma_split_mode
    import dma_split_pkg::*;
#(
    parameter int SIZE_W = 32
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [SIZE_W-1:0] len,
    output logic              words_mode,
    output logic [SIZE_W-1:0] elems
);
    always_comb begin
        words_mode = (src[1:0] == 2'b00) && (dst[1:0] == 2'b00) && (len[1:0] == 2'b00);
        elems      = words_mode ? (len >> 2) : len;
    end
endmodule

// File: rtl/dma_split_chunk.sv
module dma_split_chunk
    import dma_split_pkg::*;
#(
    parameter int SIZE_W = 32
) (
    input  logic [SIZE_W-1:0] remaining,
    input  logic              words_mode,
    output logic [CNT_W-1:0]  count,
    output logic              last,
    output logic [ADDR_W-1:0] step
);
    localparam logic [SIZE_W-1:0] LIMIT = SIZE_W'(CNT_MAX);

    always_comb begin
        last  = (remaining <= LIMIT);
        count = last ? remaining[CNT_W-1:0] : CNT_MAX;
        step  = words_mode ? {{(ADDR_W-CNT_W-2){1'b0}}, count, 2'b00}
                           : {{(ADDR_W-CNT_W){1'b0}}, count};
    end
endmodule

// File: rtl/dma_split_wordmux.sv
module dma_split_wordmux
    import dma_split_pkg::*;
(
    input  word_sel_e          sel,
    input  addr_pair_t         addrs,
    input  logic               words_mode,
    input  logic [CNT_W-1:0]   count,
    output logic [WORD_W-1:0]  data
);
    always_comb begin
        unique case (sel)
            W_HDR:    data = build_header(words_mode, count);
            W_DST_LO: data = addrs.dst[WORD_W-1:0];
            W_SRC_LO: data = addrs.src[WORD_W-1:0];
            W_DST_HI: data = hi_word(addrs.dst);
            W_SRC_HI: data = hi_word(addrs.src);
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/dma_copy_splitter.sv
module dma_copy_splitter
    import dma_split_pkg::*;
#(
    parameter int SIZE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [39:0]       req_src,
    input  logic [39:0]       req_dst,
    input  logic [SIZE_W-1:0] req_len,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [31:0]       cmd_data,
    output logic              done
);
    split_state_e      state_q;
    word_sel_e         sel_q;
    addr_pair_t        addr_q;
    logic [SIZE_W-1:0] rem_q;
    logic              words_q;
    logic              done_q;

    logic              in_words;
    logic [SIZE_W-1:0] in_elems;
    logic [CNT_W-1:0]  pkt_count;
    logic              pkt_last;
    logic [ADDR_W-1:0] pkt_step;
    logic              accept;
    logic              word_take;
    logic              pkt_end;

    dma_split_mode #(.SIZE_W(SIZE_W)) u_mode (
        .src        (req_src),
        .dst        (req_dst),
        .len        (req_len),
        .words_mode (in_words),
        .elems      (in_elems)
    );

    dma_split_chunk #(.SIZE_W(SIZE_W)) u_chunk (
        .remaining  (rem_q),
        .words_mode (words_q),
        .count      (pkt_count),
        .last       (pkt_last),
        .step       (pkt_step)
    );

    dma_split_wordmux u_mux (
        .sel        (sel_q),
        .addrs      (addr_q),
        .words_mode (words_q),
        .count      (pkt_count),
        .data       (cmd_data)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign cmd_valid = (state_q == ST_SEND);
    assign done      = done_q;
    assign accept    = req_valid && req_ready;
    assign word_take = cmd_valid && cmd_ready;
    assign pkt_end   = word_take && (sel_q == W_SRC_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= W_HDR;
            addr_q  <= '0;
            rem_q   <= '0;
            words_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                addr_q.src <= req_src;
                addr_q.dst <= req_dst;
                rem_q      <= in_elems;
                words_q    <= in_words;
                sel_q      <= W_HDR;
                if (in_elems == '0) begin
                    done_q <= 1'b1;
                end else begin
                    state_q <= ST_SEND;
                end
            end else if (word_take) begin
                if (pkt_end) begin
                    sel_q      <= W_HDR;
                    addr_q.src <= addr_q.src + pkt_step;
                    addr_q.dst <= addr_q.dst + pkt_step;
                    rem_q      <= rem_q - SIZE_W'(pkt_count);
                    if (pkt_last) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end else begin
                    sel_q <= word_sel_e'(sel_q + 3'd1);
                end
            end
        end
    end
endmodule

// File: rtl/dma_copy_splitter_chk.sv
module dma_copy_splitter_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [31:0] cmd_data,
    input logic        done
);
    logic [2:0] wpos;

    always_ff @(posedge clk) begin
        if (rst) begin
            wpos <= 3'd0;
        end else if (cmd_valid && cmd_ready) begin
            wpos <= (wpos == 3'd4) ? 3'd0 : wpos + 3'd1;
        end
    end

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data))); // R9
    AST_HDR_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && wpos == 3'd0) |-> (cmd_data[31:28] == 4'h3)); // R1
    AST_HDR_SUBCMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && wpos == 3'd0) |-> (cmd_data[27:20] == 8'h00 || cmd_data[27:20] == 8'h40)); // R2
    AST_HDR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && wpos == 3'd0) |-> (cmd_data[19:0] != 20'd0)); // R4
    AST_HI_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && wpos >= 3'd3) |-> (cmd_data[31:8] == 24'd0)); // R5
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !req_ready); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_WHOLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (wpos == 3'd0 && !cmd_valid)); // R10
endmodule

bind dma_copy_splitter dma_copy_splitter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .done      (done)
);

// File: tb/dma_copy_splitter_tb.sv
module dma_copy_splitter_tb;
    localparam int SIZE_W = 32;
    localparam int NVEC   = 10;
    localparam int MAXW   = 64;

    typedef struct packed {
        logic [39:0]       src;
        logic [39:0]       dst;
        logic [SIZE_W-1:0] len;
        logic [7:0]        rdy;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{40'h00_1000_0000, 40'h00_2000_0000, 32'd64,        8'hFF}, // R2 aligned
        '{40'h12_3456_7801, 40'h00_0000_1000, 32'd10,        8'hA5}, // R3 odd src
        '{40'h00_0000_4000, 40'h00_0000_8000, 32'd13,        8'h77}, // R3 odd length
        '{40'h00_0000_4000, 40'h00_0000_8002, 32'd20,        8'h3C}, // R3 offset dst
        '{40'h00_FFFF_FFF0, 40'h00_0010_0000, 32'h0040_0000, 8'hFF}, // R4 R6 dword split
        '{40'h01_0000_0001, 40'h00_0000_0000, 32'h0020_0000, 8'hDB}, // R4 byte 3 packets
        '{40'h00_0000_0000, 40'h00_0000_0100, 32'h003F_FFFC, 8'h96}, // R4 exactly max
        '{40'h00_0000_0000, 40'hFF_FFFF_FFFC, 32'h0040_0000, 8'hF0}, // R6 wrap 40 bits
        '{40'h00_0000_0003, 40'h00_0000_0003, 32'd0,         8'hFF}, // R7 zero
        '{40'hAB_CDEF_0124, 40'h55_0000_0008, 32'd4,         8'h01}  // R2 one dword
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [39:0]       req_src;
    logic [39:0]       req_dst;
    logic [SIZE_W-1:0] req_len;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [31:0]       cmd_data;
    logic              done;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_w [MAXW];
    int n_exp;

    always #5 clk = ~clk;

    dma_copy_splitter #(.SIZE_W(SIZE_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build_expected(input logic [39:0] s, input logic [39:0] d, input logic [SIZE_W-1:0] l);
        longint src_a = longint'(s);
        longint dst_a = longint'(d);
        bit     wm    = (s % 4 == 0) && (d % 4 == 0) && (l % 4 == 0);
        longint left  = wm ? longint'(l) / 4 : longint'(l);
        longint mask  = (longint'(1) << 40) - 1;
        n_exp = 0;
        while (left > 0) begin
            longint c = (left > 64'hFFFFF) ? 64'hFFFFF : left;
            exp_w[n_exp]   = {4'h3, (wm ? 8'h00 : 8'h40), c[19:0]};
            exp_w[n_exp+1] = dst_a[31:0];
            exp_w[n_exp+2] = src_a[31:0];
            exp_w[n_exp+3] = {24'd0, dst_a[39:32]};
            exp_w[n_exp+4] = {24'd0, src_a[39:32]};
            n_exp += 5;
            src_a = (src_a + (wm ? c * 4 : c)) & mask;
            dst_a = (dst_a + (wm ? c * 4 : c)) & mask;
            left  = left - c;
        end
    endtask

    task automatic run_req(input vec_t v);
        int  idx = 0;
        int  cyc = 0;
        bit  fin = 0;
        bit  prev_stall = 0;
        logic [31:0] prev_data = '0;
        build_expected(v.src, v.dst, v.len);
        @(negedge clk);
        check(req_ready == 1'b1, "R8 idle ready", longint'(req_ready), 1);
        req_valid = 1'b1;
        req_src   = v.src;
        req_dst   = v.dst;
        req_len   = v.len;
        @(posedge clk);
        while (!fin) begin
            @(negedge clk);
            if (done) begin
                check(idx == n_exp, "R10 done after final word", longint'(idx), longint'(n_exp));
                check(!cmd_valid, "R7 no word with done", longint'(cmd_valid), 0);
                fin = 1;
                req_valid = 1'b0;
            end else begin
                check(!req_ready, "R8 busy refuses", longint'(req_ready), 0);
                if (prev_stall)
                    check(cmd_valid && cmd_data == prev_data, "R9 word held",
                          longint'(cmd_data), longint'(prev_data));
                cmd_ready = v.rdy[cyc % 8];
                if (cmd_valid && cmd_ready) begin
                    if (idx < n_exp)
                        check(cmd_data == exp_w[idx], "R1 R4 R5 R6 word", longint'(cmd_data), longint'(exp_w[idx]));
                    else
                        check(1'b0, "R7 extra word", longint'(cmd_data), 0);
                    idx++;
                end
                prev_stall = cmd_valid && !cmd_ready;
                prev_data  = cmd_data;
                req_valid  = (idx < n_exp);
                req_src    = 40'h77_7777_7777;
                req_dst    = 40'h33_3333_3331;
                req_len    = 32'd999;
                cyc++;
                if (cyc > 2000) begin
                    check(1'b0, "R10 watchdog", longint'(idx), longint'(n_exp));
                    fin = 1;
                end
            end
        end
        @(negedge clk);
        check(!done, "R10 done one cycle", longint'(done), 0);
        cmd_ready = 1'b0;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; cmd_ready = 1'b0;
        req_src = '0; req_dst = '0; req_len = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!cmd_valid, "R11 reset valid", longint'(cmd_valid), 0);
        check(!done, "R11 reset done", longint'(done), 0);
        check(req_ready, "R11 reset ready", longint'(req_ready), 1);
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) run_req(VECS[i]);
        // R7 zero-length with misaligned addresses directly after a transfer
        run_req('{40'h00_0000_0001, 40'h00_0000_0002, 32'd0, 8'h0F});
        // R3 length just below a dword multiple, single packet with full back-pressure gaps
        run_req('{40'h00_0000_0010, 40'h00_0000_0020, 32'd7, 8'h11});
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R10 global watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule